// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects 32 level-sensitive hardware request lines and a software request register. It picks one winner among the requests that are pending and enabled, and presents that winner to a processor. Each line has its own configuration word that holds a 6-bit priority, a non-maskable flag and a 6-bit shadow register-set number. The winner is the pending line with the highest priority. For that line the block forms a handler address from the line index, a power-of-two table entry size and a table base. It drives this address, together with the line's priority, register set and non-maskable flag, while the request output is high.

Software programs the block through a plain word-addressed port with valid, write, address and data signals. Read data is registered. The enable and software-request registers each have set and clear aliases, so one bit can change without a read-modify-write. The status and vector-address registers are recomputed from the live state every cycle, so they follow any change on an input line or any register write one clock later.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Reset clears all state: every configuration word, enable, software requests, controller config, vector base, status, vector address and read data. After reset all processor-facing outputs are low.
- R2: A line configuration word sits at word index 0..31. Bits [5:0] hold the priority, bit 6 the non-maskable flag and bits [12:7] the register-set number. Bits 31..13 read as zero.
- R3: Hardware lines pass through two flops before they reach the raw status register (word 36, read-only). The pending register (word 35, read-only) reads (raw | software) & enable.
- R4: Word 32 writes the enable register directly. Word 33 ORs the data into it and word 34 clears the bits that are set in the data. Words 33 and 34 read as zero.
- R5: Word 37 writes the software request register directly. Word 38 ORs the data into it and word 39 clears the bits that are set in the data. Words 38 and 39 read as zero.
- R6: The winner is the pending line with the strictly greatest priority. When priorities tie, the lowest-numbered line wins.
- R7: A pending line with priority 0 never wins. When there is no winner, the request output is low and the status (word 41) and vector address (word 43) read zero.
- R8: The controller config (word 40) keeps only bits [2:0]; the other bits read as zero. The vector address is index × (1 << (2 + config[2:0])) + vector base (word 42).
- R9: While a winner exists, the status reads as the winner index with bit 31 set.
- R10: While a winner exists, the request output is high. The handler, level, register-set and non-maskable outputs carry the winner's vector address, priority, register set and flag.
- R11: Reads of unmapped words (44..63) return zero. Writes to read-only words (35, 36, 41, 43) and to unmapped words change nothing.
- R12: The word index is address[7:2], and address bits [1:0] are ignored. Read data appears in the cycle after the read request and is zero in every cycle that does not follow a read. Outputs and the status and vector registers update one clock after the write or synchronized input change that affects them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Asynchronous level request lines |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address; word index is bits [7:2] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_handler | output | 32 | Handler (vector) address of the winner |
| cpu_level | output | 6 | Priority of the winner |
| cpu_regset | output | 6 | Register-set number of the winner |
| cpu_nmi | output | 1 | Non-maskable flag of the winner |

## Verification
The selection logic is exercised with four request patterns. A single enabled line at priority zero shows that a request with nothing behind it stays invisible. Two equal-priority lines, one software and one hardware, tell the tie rule apart from plain scan order. Raising the higher line's priority shows that a strictly greater level wins over the lower index. Finally, clearing every enable removes the winner. The entry size is swept over three config values, so a wrong shift or a dropped base shows up as a distinct address. Writes to read-only words, an access with nonzero low address bits, and a check taken one cycle early separate the address decoding from the output timing.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NLINES  = 32;
  localparam int DATA_W  = 32;
  localparam int LVL_W   = 6;
  localparam int RS_W    = 6;
  localparam int WORD_AW = 6;
  localparam int CTRL_W  = 3;
  localparam int IDX_W   = $clog2(NLINES);
  localparam int CFG_W   = LVL_W + 1 + RS_W;

  // word indices of the non-line registers
  localparam logic [WORD_AW-1:0] W_EN     = 6'd32;
  localparam logic [WORD_AW-1:0] W_EN_SET = 6'd33;
  localparam logic [WORD_AW-1:0] W_EN_CLR = 6'd34;
  localparam logic [WORD_AW-1:0] W_PEND   = 6'd35;
  localparam logic [WORD_AW-1:0] W_RAW    = 6'd36;
  localparam logic [WORD_AW-1:0] W_SW     = 6'd37;
  localparam logic [WORD_AW-1:0] W_SW_SET = 6'd38;
  localparam logic [WORD_AW-1:0] W_SW_CLR = 6'd39;
  localparam logic [WORD_AW-1:0] W_CTRL   = 6'd40;
  localparam logic [WORD_AW-1:0] W_STAT   = 6'd41;
  localparam logic [WORD_AW-1:0] W_VBASE  = 6'd42;
  localparam logic [WORD_AW-1:0] W_VADDR  = 6'd43;

  // packed so that bit positions match the software view: lvl [5:0], nmi [6], rs [12:7]
  typedef struct packed {
    logic [RS_W-1:0]  rs;
    logic             nmi;
    logic [LVL_W-1:0] lvl;
  } line_cfg_t;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q_sync <= '0;
    end else begin
      meta_q <= d_async;
      q_sync <= meta_q;
    end
  end
endmodule

// File: rtl/vic_regfile.sv
module vic_regfile
  import vic_pkg::*;
#(
  parameter int N = NLINES
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [WORD_AW-1:0]        wr_word,
  input  logic [DATA_W-1:0]         wdata,
  output line_cfg_t [N-1:0]         cfg_q,
  output logic [N-1:0]              en_q,
  output logic [N-1:0]              sw_q,
  output logic [CTRL_W-1:0]         ctrl_q,
  output logic [DATA_W-1:0]         vbase_q
);
  localparam int LINE_SEL_W = $clog2(N);

  // one config word per line; each is written only when its own index matches
  for (genvar g = 0; g < N; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[g] <= '0;
      end else if (wr_en && (wr_word == WORD_AW'(g))) begin
        cfg_q[g] <= line_cfg_t'(wdata[CFG_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      sw_q    <= '0;
      ctrl_q  <= '0;
      vbase_q <= '0;
    end else if (wr_en) begin
      case (wr_word)
        W_EN:     en_q    <= wdata[N-1:0];
        W_EN_SET: en_q    <= en_q | wdata[N-1:0];
        W_EN_CLR: en_q    <= en_q & ~wdata[N-1:0];
        W_SW:     sw_q    <= wdata[N-1:0];
        W_SW_SET: sw_q    <= sw_q | wdata[N-1:0];
        W_SW_CLR: sw_q    <= sw_q & ~wdata[N-1:0];
        W_CTRL:   ctrl_q  <= wdata[CTRL_W-1:0];
        W_VBASE:  vbase_q <= wdata;
        default:  ;
      endcase
    end
  end

  logic unused_sel;
  assign unused_sel = ^LINE_SEL_W;

  // R4: set alias leaves every written bit high
  a_r4_en_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_word == W_EN_SET) |=> ((en_q & $past(wdata[N-1:0])) == $past(wdata[N-1:0])));
  // R4: clear alias leaves every written bit low
  a_r4_en_clr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_word == W_EN_CLR) |=> ((en_q & $past(wdata[N-1:0])) == '0));
  // R5: software set alias
  a_r5_sw_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_word == W_SW_SET) |=> ((sw_q & $past(wdata[N-1:0])) == $past(wdata[N-1:0])));
  // R5: software clear alias
  a_r5_sw_clr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_word == W_SW_CLR) |=> ((sw_q & $past(wdata[N-1:0])) == '0));
  // R11: read-only words never disturb the vector base
  a_r11_ro_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_word == W_VADDR || wr_word == W_STAT)) |=> $stable(vbase_q));
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int N = NLINES
) (
  input  logic [N-1:0]       pend,
  input  line_cfg_t [N-1:0]  cfg,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output logic [LVL_W-1:0]   win_lvl,
  output logic [RS_W-1:0]    win_rs,
  output logic               win_nmi
);
  // ascending scan with strict compare: a tie keeps the lower index,
  // and a best level starting at zero means level 0 never wins
  always_comb begin
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && (cfg[i].lvl > win_lvl)) begin
        win_idx = IDX_W'(i);
        win_lvl = cfg[i].lvl;
      end
    end
    win_valid = (win_lvl != '0);
    win_rs    = win_valid ? cfg[win_idx].rs  : '0;
    win_nmi   = win_valid ? cfg[win_idx].nmi : 1'b0;
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       irq_in,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              cpu_irq,
  output logic [31:0]       cpu_handler,
  output logic [5:0]        cpu_level,
  output logic [5:0]        cpu_regset,
  output logic              cpu_nmi
);
  localparam int SH_W = 4;

  logic [WORD_AW-1:0]      word;
  logic [NLINES-1:0]       raw;
  line_cfg_t [NLINES-1:0]  cfg;
  logic [NLINES-1:0]       en, sw, pend;
  logic [CTRL_W-1:0]       ctrl;
  logic [DATA_W-1:0]       vbase;
  logic                    w_valid, w_nmi;
  logic [IDX_W-1:0]        w_idx;
  logic [LVL_W-1:0]        w_lvl;
  logic [RS_W-1:0]         w_rs;
  logic [SH_W-1:0]         shamt;
  logic [DATA_W-1:0]       vaddr_next;
  logic [DATA_W-1:0]       status_q, vaddr_q;
  logic [DATA_W-1:0]       rd_mux;
  logic                    unused_lo;

  assign word      = reg_addr[7:2];
  assign unused_lo = ^reg_addr[1:0];

  vic_sync #(.W(NLINES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (irq_in),
    .q_sync  (raw)
  );

  vic_regfile #(.N(NLINES)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_valid && reg_write),
    .wr_word (word),
    .wdata   (reg_wdata),
    .cfg_q   (cfg),
    .en_q    (en),
    .sw_q    (sw),
    .ctrl_q  (ctrl),
    .vbase_q (vbase)
  );

  assign pend = (raw | sw) & en;

  vic_arbiter #(.N(NLINES)) u_arb (
    .pend      (pend),
    .cfg       (cfg),
    .win_valid (w_valid),
    .win_idx   (w_idx),
    .win_lvl   (w_lvl),
    .win_rs    (w_rs),
    .win_nmi   (w_nmi)
  );

  assign shamt      = SH_W'(2) + SH_W'(ctrl);
  assign vaddr_next = (DATA_W'(w_idx) << shamt) + vbase;

  // registered winner view: status, vector address and processor outputs
  always_ff @(posedge clk) begin
    if (rst || !w_valid) begin
      status_q   <= '0;
      vaddr_q    <= '0;
      cpu_irq    <= 1'b0;
      cpu_level  <= '0;
      cpu_regset <= '0;
      cpu_nmi    <= 1'b0;
    end else begin
      status_q   <= {1'b1, (DATA_W-1)'(w_idx)};
      vaddr_q    <= vaddr_next;
      cpu_irq    <= 1'b1;
      cpu_level  <= w_lvl;
      cpu_regset <= w_rs;
      cpu_nmi    <= w_nmi;
    end
  end

  assign cpu_handler = vaddr_q;

  // read decode; write-only aliases and unmapped words fall to zero
  always_comb begin
    rd_mux = '0;
    if (word < WORD_AW'(NLINES)) begin
      rd_mux = DATA_W'(cfg[word[IDX_W-1:0]]);
    end else begin
      case (word)
        W_EN:    rd_mux = en;
        W_PEND:  rd_mux = pend;
        W_RAW:   rd_mux = raw;
        W_SW:    rd_mux = sw;
        W_CTRL:  rd_mux = DATA_W'(ctrl);
        W_STAT:  rd_mux = status_q;
        W_VBASE: rd_mux = vbase;
        W_VADDR: rd_mux = vaddr_q;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !(reg_valid && !reg_write)) reg_rdata <= '0;
    else                                   reg_rdata <= rd_mux;
  end

  // R7/R10: a raised request never carries a zero priority
  a_r7_level_nonzero: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> (cpu_level != '0));
  // R7: with no request, status and vector address read zero
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !cpu_irq |-> (status_q == '0 && cpu_handler == '0));
  // R9: status flag tracks the request line
  a_r9_status_flag: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> (status_q[DATA_W-1] && status_q[DATA_W-2:IDX_W] == '0));
  // R12: read data is zero unless a read was issued the cycle before
  a_r12_rdata_idle: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_valid && !reg_write) |-> (reg_rdata == '0));
endmodule

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, cpu_handler;
  logic        cpu_irq, cpu_nmi;
  logic [5:0]  cpu_level, cpu_regset;

  int tests = 0, fails = 0;
  bit done = 0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl u_vec_irq_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq(cpu_irq), .cpu_handler(cpu_handler), .cpu_level(cpu_level),
    .cpu_regset(cpu_regset), .cpu_nmi(cpu_nmi)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: a read captured at a posedge is compared at the next negedge
  always @(posedge clk) rd_seen <= reg_valid && !reg_write && !rst;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R12: read data with no expected item, actual %h expected none", reg_rdata);
      end else begin
        check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input int w, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 8'(w << 2); reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input int w, input logic [31:0] exp, input string tag, input logic [1:0] lo = 2'b00);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = {6'(w), lo};
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_out(string tag, logic irq, logic [31:0] h, logic [5:0] l, logic [5:0] r, logic n);
    check({tag, " irq"}, 32'(cpu_irq), 32'(irq));
    check({tag, " handler"}, cpu_handler, h);
    check({tag, " level"}, 32'(cpu_level), 32'(l));
    check({tag, " regset"}, 32'(cpu_regset), 32'(r));
    check({tag, " nmi"}, 32'(cpu_nmi), 32'(n));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst = 1'b0;
    settle(1);
    // R1: reset state
    check_out("R1 reset", 0, 0, 0, 0, 0);
    check("R1 rdata", reg_rdata, 0);
    rd(32, 0, "R1 enable");
    rd(0, 0, "R1 cfg0");
    rd(41, 0, "R1 status");
    rd(43, 0, "R1 vaddr");

    // R2: config fields, upper bits dropped
    wr(3, 32'hFFFF_FFFF);
    rd(3, 32'h0000_1FFF, "R2 cfg upper bits");
    wr(3, 32'h0);

    // R4: enable aliases
    wr(32, 32'h0F);
    wr(33, 32'hF0);
    rd(32, 32'hFF, "R4 enable set");
    wr(34, 32'h0F);
    rd(32, 32'hF0, "R4 enable clear");
    rd(33, 0, "R4 set alias reads zero");

    // R5: software aliases
    wr(37, 32'h1);
    wr(38, 32'h4);
    rd(37, 32'h5, "R5 sw set");
    wr(39, 32'h1);
    rd(37, 32'h4, "R5 sw clear");
    rd(39, 0, "R5 clear alias reads zero");
    rd(35, 0, "R3 pending masked by enable");

    // R7: pending line at level 0 never wins
    wr(33, 32'h4);
    settle(1);
    rd(35, 32'h4, "R3 pending sw");
    check_out("R7 level zero", 0, 0, 0, 0, 0);
    rd(41, 0, "R7 status zero");
    rd(43, 0, "R7 vaddr zero");

    // R8/R9/R10: single winner, entry size 4
    wr(42, 32'h1000);
    wr(2, 32'h185);
    settle(1);
    check_out("R10 single winner", 1, 32'h1008, 5, 3, 0);
    rd(41, 32'h8000_0002, "R9 status");
    rd(43, 32'h1008, "R8 vaddr size4");

    // R6: tie at level 5 between sw line 2 and hw line 5
    wr(5, 32'h45);
    irq_in[5] = 1'b1;
    settle(4);
    rd(36, 32'h20, "R3 raw status");
    rd(35, 32'h24, "R3 pending hw+sw");
    check_out("R6 tie lowest index", 1, 32'h1008, 5, 3, 0);

    // R6: strictly greater level wins
    wr(5, 32'h46);
    settle(1);
    check_out("R6 higher level", 1, 32'h1014, 6, 0, 1);

    // R8: entry sizes 32 and 512, config upper bits dropped
    wr(40, 32'h3);
    settle(1);
    check("R8 size32", cpu_handler, 32'h10A0);
    wr(40, 32'hFFFF_FFFF);
    rd(40, 32'h7, "R8 ctrl upper bits");
    settle(1);
    check("R8 size512", cpu_handler, 32'h1A00);

    // R11: writes to read-only and unmapped words ignored
    wr(43, 32'h1234);
    wr(41, 32'h0);
    wr(35, 32'h0);
    wr(36, 32'hFFFF);
    wr(50, 32'hFFFF);
    settle(1);
    rd(43, 32'h1A00, "R11 vaddr write ignored");
    rd(41, 32'h8000_0005, "R11 status write ignored");
    rd(35, 32'h24, "R11 pending write ignored");
    rd(36, 32'h20, "R11 raw write ignored");
    rd(50, 0, "R11 unmapped reads zero");
    rd(42, 32'h1000, "R11 vbase unchanged");
    // R12: low address bits ignored
    rd(35, 32'h24, "R12 low addr bits", 2'b11);

    // R12: output lags a write by one clock
    wr(2, 32'h187);
    check("R12 before update level", 32'(cpu_level), 6);
    settle(1);
    check_out("R12 after update", 1, 32'h1400, 7, 3, 0);

    // R7: disable all, no winner
    wr(32, 32'h0);
    settle(1);
    check_out("R7 all disabled", 0, 0, 0, 0, 0);
    rd(41, 0, "R7 status cleared");

    // R1: reset clears config words
    @(negedge clk); rst = 1'b1;
    settle(2);
    rst = 1'b0;
    rd(5, 0, "R1 cfg5 after reset");
    rd(42, 0, "R1 vbase after reset");
    settle(2);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule